// File: doc/BRIEF.md
# Memory-Stall Power-Gate Predictor

This controller sits beside one core. It watches the core's memory misses and decides whether the core can be power gated while it waits for main memory. When a miss starts, the block counts clock cycles. A miss that outlives the last-level-cache hit latency is treated as a trip to main memory. The block then predicts how long the whole stall will take, using the row-buffer-miss latency plus a learned signed correction. If the predicted remaining wait is long enough to pay back a wake-up, the block raises a gate request.

While the core is gated, the block fires a one-cycle wake trigger ahead of the predicted response by the core's current wake-up latency. The core is then powered again about when the data returns. When the response arrives, the block compares the real stall with its prediction and adjusts the correction. It drops the correction at once after an over-prediction. It follows an under-prediction slowly, through a 13/16 : 3/16 running average.

Top module: `mem_stall_gate_ctl`

## Requirements
- R1: After reset, `gate_req_o` and `wake_trig_o` are low and the correction is zero.
- R2: A request seen while no miss is tracked starts tracking. The request clock edge counts as edge 1, and the stall length is the number of edges from edge 1 up to the response edge. A request while a miss is tracked is ignored and does not restart the count.
- R3: The prediction is P = max(0, row-miss latency + correction). The gate decision is taken once per miss, at the first edge whose sampled stall count exceeds the cache-hit latency L, which is edge L+2. If P − (L+1) > wake latency + margin, `gate_req_o` rises after that edge. Otherwise it stays low for that miss.
- R4: While gated, the block samples the stall count c at each edge. At the first edge where c + wake latency ≥ P, which is edge P−W+1, `wake_trig_o` pulses high for exactly one cycle. `gate_req_o` falls on that same edge.
- R5: If the response edge comes while the core is gated and no trigger has fired yet, the trigger fires on that response edge and `gate_req_o` falls with it.
- R6: On the response, beta = actual stall − P. If beta is negative, the correction becomes correction + beta.
- R7: If beta is zero or positive, the correction becomes floor(13·correction/16) + floor(3·beta/16).
- R8: A response while no miss is tracked is ignored. It produces no output and leaves the correction unchanged.
- R9: A miss that is not gated produces no trigger, but its response still updates the correction.
- R10: The correction is a signed 16-bit value that saturates at −32768 and +32767 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Memory miss issued (one-cycle strobe) |
| resp_i | input | 1 | Memory response returned (one-cycle strobe) |
| llc_hit_lat_i | input | CW | Last-level-cache hit latency in cycles |
| row_miss_lat_i | input | CW | Row-buffer-miss latency in cycles |
| wake_lat_i | input | CW | Current core wake-up latency in cycles |
| margin_i | input | CW | Break-even margin in cycles |
| gate_req_o | output | 1 | Request to power gate the core |
| wake_trig_o | output | 1 | One-cycle pulse that starts the wake-up |

## Verification
The misses are driven with responses that land exactly on the prediction, that land early enough to pre-empt the scheduled trigger, and that land late. These three cases separate the zero-error path, the early-wake path with its downward snap of the correction, and the upward averaging path. The correction cannot be seen at the ports. Each update is therefore judged by when the gate and trigger edges fall on the following miss. Further runs add a stray request in mid-miss, a stray response while idle, a short predicted stall that must not gate, and a huge over-prediction that drives the correction into its lower limit. These show that the count is not restarted, that idle responses are dropped, that ungated misses still train the predictor, and that the correction saturates instead of wrapping.

// File: rtl/mem_stall_gate_ctl.sv
module mem_stall_gate_ctl #(
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          resp_i,
  input  logic [CW-1:0] llc_hit_lat_i,
  input  logic [CW-1:0] row_miss_lat_i,
  input  logic [CW-1:0] wake_lat_i,
  input  logic [CW-1:0] margin_i,
  output logic          gate_req_o,
  output logic          wake_trig_o
);
  localparam int SW = ((CW > DW) ? CW : DW) + 4;
  localparam logic signed [SW-1:0] DMAX = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [SW-1:0] DMIN = -DMAX - SW'(1);

  logic                 busy, decided, gate_q, wake_q;
  logic [CW-1:0]        cnt;
  logic signed [DW-1:0] delta_q, delta_sat;
  logic signed [SW-1:0] cnt_s, wake_s, marg_s, dext, pred_raw, pred;
  logic signed [SW-1:0] beta, nxt_neg, nxt_pos, nxt;
  logic                 gate_ok, wake_due;

  assign cnt_s    = $signed({{(SW-CW){1'b0}}, cnt});
  assign wake_s   = $signed({{(SW-CW){1'b0}}, wake_lat_i});
  assign marg_s   = $signed({{(SW-CW){1'b0}}, margin_i});
  assign dext     = {{(SW-DW){delta_q[DW-1]}}, delta_q};
  assign pred_raw = $signed({{(SW-CW){1'b0}}, row_miss_lat_i}) + dext;
  assign pred     = pred_raw[SW-1] ? '0 : pred_raw;

  assign gate_ok  = (pred - cnt_s) > (wake_s + marg_s);
  assign wake_due = (cnt_s + wake_s) >= pred;

  assign beta     = cnt_s - pred;
  assign nxt_neg  = dext + beta;
  assign nxt_pos  = ((dext * 5'sd13) >>> 4) + ((beta * 5'sd3) >>> 4);
  assign nxt      = beta[SW-1] ? nxt_neg : nxt_pos;
  assign delta_sat = (nxt > DMAX) ? DMAX[DW-1:0] :
                     (nxt < DMIN) ? DMIN[DW-1:0] : nxt[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      decided <= 1'b0;
      gate_q  <= 1'b0;
      wake_q  <= 1'b0;
      cnt     <= '0;
      delta_q <= '0;
    end else begin
      wake_q <= 1'b0;
      if (!busy) begin
        if (req_i) begin
          busy    <= 1'b1;
          decided <= 1'b0;
          cnt     <= CW'(1);
        end
      end else if (resp_i) begin
        busy    <= 1'b0;
        delta_q <= delta_sat;
        if (gate_q) begin
          gate_q <= 1'b0;
          wake_q <= 1'b1;
        end
      end else begin
        if (cnt != '1) cnt <= cnt + CW'(1);
        if (!decided && cnt > llc_hit_lat_i) begin
          decided <= 1'b1;
          gate_q  <= gate_ok;
        end else if (gate_q && wake_due) begin
          gate_q <= 1'b0;
          wake_q <= 1'b1;
        end
      end
    end
  end

  assign gate_req_o  = gate_q;
  assign wake_trig_o = wake_q;

  // R4
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_trig_o |=> !wake_trig_o);
  // R4
  wake_ends_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_trig_o |-> $fell(gate_req_o));
  // R3
  gate_rise_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_req_o) |-> ($past(cnt) > $past(llc_hit_lat_i)));
  // R2
  gate_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_req_o |-> busy);
  // R8
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_i && busy) |=> $stable(delta_q));
  // R10
  delta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_i && busy && beta[SW-1] && (nxt_neg < DMIN)) |=> (delta_q == DMIN[DW-1:0]));
endmodule

// File: tb/mem_stall_gate_ctl_test.sv
`timescale 1ns/1ps
module mem_stall_gate_ctl_test;
  localparam int L = 10, W = 8, M = 4;
  localparam int EV_GATE = 0, EV_WAKE = 1;

  typedef struct {int kind; int off; string tag;} ev_t;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, resp = 1'b0;
  logic [15:0] llc = 16'(L), rowm = 16'd50, wlat = 16'(W), marg = 16'(M);
  logic gate, wake, gate_prev;
  int off = 0, nchk = 0, nfail = 0, dm = 0;
  bit done = 0;
  ev_t q[$];

  always #2.5 clk = ~clk;

  mem_stall_gate_ctl uut (.clk(clk), .rst_n(rst_n), .req_i(req), .resp_i(resp),
    .llc_hit_lat_i(llc), .row_miss_lat_i(rowm), .wake_lat_i(wlat), .margin_i(marg),
    .gate_req_o(gate), .wake_trig_o(wake));

  always @(posedge clk) off <= off + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic observe(int kind);
    ev_t e;
    if (q.size() == 0) begin
      chk(0, "R3/R4/R9", kind == EV_GATE ? "unexpected gate" : "unexpected wake", off, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, e.tag, "event kind", kind, e.kind);
      chk(e.off == off, e.tag, "event offset", off, e.off);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (gate && !gate_prev) observe(EV_GATE);
      if (wake) observe(EV_WAKE);
    end
    gate_prev = gate;
  end

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic miss(int r, bit extra, string tag);
    int p, beta, wo;
    bit gated;
    ev_t e;
    p = int'(rowm) + dm;
    if (p < 0) p = 0;
    gated = (r > L + 1) && ((p - (L + 1)) > (W + M));
    if (gated) begin
      e.kind = EV_GATE; e.off = L + 2; e.tag = tag; q.push_back(e);
      wo = (p - W + 1 < r + 1) ? p - W + 1 : r + 1;
      e.kind = EV_WAKE; e.off = wo; e.tag = tag; q.push_back(e);
    end
    beta = r - p;
    if (beta < 0) dm = sat(dm + beta);
    else dm = sat(((13 * dm) >>> 4) + ((3 * beta) >>> 4));
    @(negedge clk);
    req = 1'b1;
    off = 0;
    @(negedge clk);
    req = 1'b0;
    while (off < r) begin
      req = (extra && off == 20);
      @(negedge clk);
    end
    req = 1'b0;
    resp = 1'b1;
    @(negedge clk);
    resp = 1'b0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, tag, "events left over", q.size(), 0);
    q.delete();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    gate_prev = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate == 1'b0, "R1", "gate after reset", gate, 0);
    chk(wake == 1'b0, "R1", "wake after reset", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);
    miss(50, 0, "R1_R3_R4_R7");
    miss(40, 0, "R5_R6");
    miss(60, 1, "R2_R7");
    miss(70, 0, "R7");
    @(negedge clk); resp = 1'b1; @(negedge clk); resp = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate == 1'b0 && wake == 1'b0, "R8", "idle response output", gate, 0);
    miss(45, 0, "R8");
    rowm = 16'd20;
    miss(30, 0, "R9");
    rowm = 16'd50;
    miss(50, 0, "R9");
    rowm = 16'd40000;
    miss(5, 0, "R10");
    rowm = 16'd32800;
    miss(32, 0, "R10");
    miss(29, 0, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule